// File: doc/BRIEF.md
# DRAM Cycle Type Decoder

This block watches the control pins of an asynchronous page-mode DRAM: row strobe, four per-lane column strobes, write enable and output enable. A fast clock samples them. Each period in which the row strobe is low is one memory cycle. When the row strobe returns high, the block reports the kind of that cycle for one clock. The report carries the cycle type, the row address, the column address and a mask of the byte lanes whose column strobe went low. All pins are active low. The block can serve as a protocol checker next to a memory controller, or as the front end of a behavioural memory model.

Classification uses only the order in which edges are seen at the sample points:

- A column strobe that is already low when the row strobe falls marks a refresh. It is a hidden refresh if that strobe has stayed low since the end of the previous access. Otherwise it is a test-mode entry if write enable is low, and a column-before-row refresh if it is not.
- A refresh of this last kind that stays low for long enough is a self refresh.
- When all column strobes are high at the row fall, the cycle is an access or a row-only refresh. Write enable decides between read, early write, output-enable-controlled write and read-modify-write. A write-enable timing that fits none of these is reported with its own error code.

The inputs are taken as already synchronous to `clk`.

Top module: `dram_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid`, `cyc_type`, `row_addr`, `col_addr` and `lane_mask` are all zero.
- R2: `cyc_valid` is high for exactly one clock. That clock follows the first sample at which `ras_n` is high after one or more samples at which it was low. At no other time is it high.
- R3: If any `cas_n` bit is low at the sample where `ras_n` falls, and no hidden refresh applies (R8), the type is 6 (column-before-row refresh). If `we_n` is also low at that sample, the type is 9 (test-mode entry).
- R4: If every `cas_n` bit is high at the row fall and stays high for the whole low period, the type is 5 (row-only refresh). `row_addr` is the `addr` value sampled at the row fall.
- R5: Only the first column-strobe fall of an access cycle is used. If `we_n` is low at that sample, the type is 2 (early write). If `we_n` never falls afterwards, the type is 1 (read). `col_addr` is loaded from `addr` at that first fall; later column-strobe falls in the same cycle leave it unchanged.
- R6: If `we_n` falls after the first column-strobe fall of a read-started cycle, and `oe_n` has not yet been sampled low in that cycle, the type is 3 (output-enable-controlled write).
- R7: If `we_n` falls after `oe_n` was sampled low (at the same sample or earlier), the outcome depends on how many samples came after the first column-strobe fall:
  - at least `RMW_DLY` samples: type 4 (read-modify-write);
  - fewer: type 10 (indeterminate).
- R8: If a column strobe is low when an access or hidden cycle ends, and no sample shows all column strobes high before the next row fall, then the next cycle is type 7 (hidden refresh). In that case `row_addr` is not reloaded.
- R9: A type-6 cycle whose row strobe stays low for `SELF_CYC` or more samples is reported as type 8 (self refresh). With one sample fewer it stays type 6. Test-mode entry stays type 9 whatever its length.
- R10: Bit i of `lane_mask` is set when `cas_n[i]` was sampled low at any sample during the row-low period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | LANES | Per-lane column strobes, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock cycle-end flag |
| cyc_type | output | 4 | Cycle type code, valid with `cyc_valid` |
| row_addr | output | ADDR_W | Latched row address |
| col_addr | output | ADDR_W | Latched column address |
| lane_mask | output | LANES | Lanes active during the cycle |

## Verification
Two functions can fall on the same sample: the end-of-cycle report of an access, and the setup of a hidden refresh. Both hinge on the column strobe that is still low as the row strobe rises. The bench provokes this by ending reads and early writes with the column strobe held low, cycling the row strobe, and only then releasing the column strobe. It expects the access report first and a type-7 report with the held lanes second. A second clash, output enable and write enable falling on the same sample, is driven at the read-modify-write boundary and just below it. The bench's reference model predicts type 4 at the boundary and type 10 below it.

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder #(
  parameter int ADDR_W   = 12,
  parameter int LANES    = 4,
  parameter int SELF_CYC = 10000,
  parameter int RMW_DLY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic [LANES-1:0]  cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              cyc_valid,
  output logic [3:0]        cyc_type,
  output logic [ADDR_W-1:0] row_addr,
  output logic [ADDR_W-1:0] col_addr,
  output logic [LANES-1:0]  lane_mask
);

  localparam int RW = $clog2(SELF_CYC + 1);
  localparam int CW = $clog2(RMW_DLY + 1);
  localparam logic [RW-1:0] SELF_LIM = RW'(SELF_CYC);
  localparam logic [CW-1:0] DLY_LIM  = CW'(RMW_DLY);

  localparam logic [3:0] T_NONE  = 4'd0;
  localparam logic [3:0] T_READ  = 4'd1;
  localparam logic [3:0] T_EWR   = 4'd2;
  localparam logic [3:0] T_OEW   = 4'd3;
  localparam logic [3:0] T_RMW   = 4'd4;
  localparam logic [3:0] T_ROR   = 4'd5;
  localparam logic [3:0] T_CBR   = 4'd6;
  localparam logic [3:0] T_HID   = 4'd7;
  localparam logic [3:0] T_SELF  = 4'd8;
  localparam logic [3:0] T_TEST  = 4'd9;
  localparam logic [3:0] T_INDET = 4'd10;

  logic             ras_q, we_q, cas_held, oe_seen;
  logic [LANES-1:0] cas_q, mask_acc;
  logic [3:0]       kind, w_kind, fin_kind;
  logic [RW-1:0]    ras_cnt;
  logic [CW-1:0]    cas_cnt;

  logic ras_fall, ras_rise, ras_low, any_cas, first_cas, w_fall, access_kind;

  assign ras_low   = ~ras_n;
  assign ras_fall  = ras_q & ~ras_n;
  assign ras_rise  = ~ras_q & ras_n;
  assign any_cas   = ~&cas_n;
  assign first_cas = ras_low & ~ras_fall & (kind == T_ROR) & (&cas_q) & any_cas;
  assign w_fall    = ras_low & ~ras_fall & (kind == T_READ) & we_q & ~we_n;

  assign access_kind = (kind == T_READ) || (kind == T_EWR) || (kind == T_OEW) ||
                       (kind == T_RMW)  || (kind == T_INDET) || (kind == T_HID);

  always_comb begin
    if (!(oe_seen || !oe_n))   w_kind = T_OEW;
    else if (cas_cnt >= DLY_LIM) w_kind = T_RMW;
    else                       w_kind = T_INDET;
  end

  assign fin_kind = (kind == T_CBR && ras_cnt >= SELF_LIM) ? T_SELF : kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      we_q      <= 1'b1;
      cas_q     <= '1;
      kind      <= T_NONE;
      cas_held  <= 1'b0;
      oe_seen   <= 1'b0;
      ras_cnt   <= '0;
      cas_cnt   <= '0;
      mask_acc  <= '0;
      cyc_valid <= 1'b0;
      cyc_type  <= T_NONE;
      row_addr  <= '0;
      col_addr  <= '0;
      lane_mask <= '0;
    end else begin
      ras_q <= ras_n;
      we_q  <= we_n;
      cas_q <= cas_n;

      if (ras_fall) begin
        if (!any_cas)      kind <= T_ROR;
        else if (cas_held) kind <= T_HID;
        else if (!we_n)    kind <= T_TEST;
        else               kind <= T_CBR;
      end else if (first_cas) begin
        kind <= we_n ? T_READ : T_EWR;
      end else if (w_fall) begin
        kind <= w_kind;
      end

      if (ras_rise)      cas_held <= any_cas & access_kind;
      else if (&cas_n)   cas_held <= 1'b0;

      if (ras_fall || first_cas)                   oe_seen <= 1'b0;
      else if (ras_low && kind == T_READ && !oe_n) oe_seen <= 1'b1;

      if (ras_fall)                          ras_cnt <= RW'(1);
      else if (ras_low && ras_cnt < SELF_LIM) ras_cnt <= ras_cnt + 1'b1;

      if (first_cas)                                          cas_cnt <= CW'(1);
      else if (ras_low && kind != T_ROR && cas_cnt < DLY_LIM) cas_cnt <= cas_cnt + 1'b1;

      if (ras_fall)     mask_acc <= ~cas_n;
      else if (ras_low) mask_acc <= mask_acc | ~cas_n;

      if (ras_fall && !any_cas) row_addr <= addr;
      if (first_cas)            col_addr <= addr;

      cyc_valid <= ras_rise;
      if (ras_rise) begin
        cyc_type  <= fin_kind;
        lane_mask <= mask_acc;
      end
    end
  end

endmodule

// File: rtl/dram_cycle_decoder_chk.sv
module dram_cycle_decoder_chk #(
  parameter int ADDR_W = 12,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cyc_valid,
  input logic [3:0]        cyc_type,
  input logic [LANES-1:0]  lane_mask,
  input logic [ADDR_W-1:0] row_addr
);

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |=> !cyc_valid);

  assert_end_follows_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> ($past(ras_n) && !$past(ras_n, 2)));

  assert_type_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (cyc_type >= 4'd1 && cyc_type <= 4'd10));

  assert_refresh_has_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type >= 4'd6 && cyc_type <= 4'd9) |-> (lane_mask != '0));

  assert_ror_no_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_type == 4'd5) |-> (lane_mask == '0));

  assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !$past(ras_n) && !$past(ras_n, 2)) |-> $stable(row_addr));

endmodule

bind dram_cycle_decoder dram_cycle_decoder_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cyc_valid(cyc_valid),
  .cyc_type(cyc_type), .lane_mask(lane_mask), .row_addr(row_addr)
);

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;
  localparam int SELF = 40;
  localparam int DLY  = 4;

  logic        clk = 1'b0, rst_n = 1'b0, ras_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [3:0]  cas_n = 4'hF;
  logic [11:0] addr = '0;
  logic        cyc_valid;
  logic [3:0]  cyc_type;
  logic [11:0] row_addr, col_addr;
  logic [3:0]  lane_mask;

  dram_cycle_decoder #(.ADDR_W(12), .LANES(4), .SELF_CYC(SELF), .RMW_DLY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type), .row_addr(row_addr),
    .col_addr(col_addr), .lane_mask(lane_mask));

  always #5 clk = ~clk;

  typedef struct { int e; int t; int m; int r; int c; bit kr; bit kc; string req; } exp_t;
  exp_t q[$];
  exp_t cur;
  int edges = 0, checks = 0, fails = 0;
  bit chk_on = 0, done = 0;

  always @(posedge clk) edges++;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) if (chk_on) begin
    if (q.size() != 0 && q[0].e == edges) begin
      cur = q.pop_front();
      check(cyc_valid == 1'b1, cur.req, "cyc_valid", int'(cyc_valid), 1);
      check(int'(cyc_type) == cur.t, cur.req, "cyc_type", int'(cyc_type), cur.t);
      check(int'(lane_mask) == cur.m, "R10", "lane_mask", int'(lane_mask), cur.m);
      if (cur.kr) check(int'(row_addr) == cur.r, cur.req, "row_addr", int'(row_addr), cur.r);
      if (cur.kc) check(int'(col_addr) == cur.c, "R5", "col_addr", int'(col_addr), cur.c);
    end else begin
      check(cyc_valid == 1'b0, "R2", "idle cyc_valid", int'(cyc_valid), 0);
    end
  end

  task automatic push_exp(int t, int m, int r, int c, bit kr, bit kc, string req);
    exp_t x;
    x.e = edges + 1; x.t = t; x.m = m; x.r = r; x.c = c; x.kr = kr; x.kc = kc; x.req = req;
    q.push_back(x);
  endtask

  task automatic ror(int row, int n);
    @(negedge clk); addr = 12'(row); ras_n = 0;
    repeat (n) @(negedge clk);
    ras_n = 1; push_exp(5, 0, row, 0, 1, 0, "R4");
    repeat (2) @(negedge clk);
  endtask

  task automatic cbr(int lanes, bit wlow, int n, string req);
    int t;
    @(negedge clk); cas_n = ~4'(lanes); we_n = !wlow;
    @(negedge clk); ras_n = 0;
    repeat (n) @(negedge clk);
    ras_n = 1;
    t = wlow ? 9 : (n >= SELF ? 8 : 6);
    push_exp(t, lanes, 0, 0, 0, 0, req);
    @(negedge clk); cas_n = 4'hF; we_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic access(int row, int col, int l1, int l2, bit early, int oe_d, int w_d,
                        bit hide, string req);
    int t, last;
    @(negedge clk); addr = 12'(row); ras_n = 0;
    @(negedge clk); addr = 12'(col); we_n = !early;
    @(negedge clk); cas_n = ~4'(l1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      if (k == oe_d) oe_n = 0;
      if (k == w_d) we_n = 0;
      if (l2 != 0 && k == 3) begin cas_n = 4'hF; addr = 12'(col + 1); end
      if (l2 != 0 && k == 4) cas_n = ~4'(l2);
    end
    if (early)                    t = 2;
    else if (w_d < 0)             t = 1;
    else if (oe_d < 0 || oe_d > w_d) t = 3;
    else if (w_d >= DLY)          t = 4;
    else                          t = 10;
    last = (l2 != 0) ? l2 : l1;
    @(negedge clk); oe_n = 1; we_n = 1; if (!hide) cas_n = 4'hF;
    @(negedge clk); ras_n = 1; push_exp(t, l1 | l2, row, col, 1, 1, req);
    if (hide) begin
      @(negedge clk);
      @(negedge clk); ras_n = 0;
      repeat (5) @(negedge clk);
      ras_n = 1; push_exp(7, last, 0, 0, 0, 0, "R8");
      @(negedge clk); cas_n = 4'hF;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1; chk_on = 1;
    @(negedge clk);
    check(cyc_valid == 0 && cyc_type == 0, "R1", "type after reset", int'(cyc_type), 0);
    check(row_addr == 0 && col_addr == 0, "R1", "addr after reset", int'(row_addr), 0);
    check(lane_mask == 0, "R1", "mask after reset", int'(lane_mask), 0);
    ror(12'hA5C, 6);
    access(12'h123, 12'h045, 4'hF, 0, 0, -1, -1, 0, "R5");   // read
    access(12'h321, 12'h0F0, 4'h5, 0, 1, -1, -1, 0, "R5");   // early write
    access(12'h111, 12'h022, 4'h3, 0, 0, -1, 3, 0, "R6");    // oe-controlled write
    access(12'h112, 12'h023, 4'h3, 0, 0, 5, 2, 0, "R6");     // OE after W
    access(12'h200, 12'h033, 4'h9, 0, 0, 1, 5, 0, "R7");     // rmw
    access(12'h201, 12'h034, 4'h9, 0, 0, 4, 4, 0, "R7");     // rmw boundary, same sample
    access(12'h202, 12'h035, 4'h9, 0, 0, 1, 3, 0, "R7");     // indeterminate below boundary
    access(12'h203, 12'h036, 4'h9, 0, 0, 2, 2, 0, "R7");     // indeterminate, same sample
    access(12'h300, 12'h040, 4'h3, 4'hC, 0, -1, -1, 0, "R5"); // fast page, col kept
    cbr(4'h2, 0, 8, "R3");
    cbr(4'h8, 1, 8, "R3");
    cbr(4'h1, 0, SELF - 1, "R9");
    cbr(4'h1, 0, SELF, "R9");
    cbr(4'h4, 1, SELF + 5, "R9");
    access(12'h400, 12'h050, 4'h6, 0, 0, -1, -1, 1, "R8");    // read then hidden
    access(12'h401, 12'h051, 4'hA, 0, 1, -1, -1, 1, "R8");    // early write then hidden
    ror(12'h0FF, 3);                                          // after hidden: no stale hold
    repeat (4) @(negedge clk);
    check(q.size() == 0, "R2", "pending reports", q.size(), 0);
  endtask

  initial begin
    fork
      begin run_all(); done = 1; end
      begin repeat (100000) @(posedge clk); end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog: done=%0d expected=1", done);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule